// File: doc/BRIEF.md
# Narrow Analog Register Bus Bridge

This block sits between a memory-mapped CPU register port and a slow, narrow bus that reaches 8-bit registers in an analog slave. A single CPU access of up to 32 bits is cut into an ordered run of slave transactions. Each slave transaction writes one byte or one nibble, or returns one nibble of read data, and always occupies three clock cycles. Address bits above the register index select how a write changes the slave register: it can replace the register, set bits, clear bits, or write under a mask. Set, clear and masked writes let software change fields without a read-modify-write.

Writes enter a small queue. A posted write is acknowledged at once and the queue drains in the background. A non-posted write holds the CPU until it has reached the slave. A read waits for the queue to drain, then runs its nibble transactions and returns the assembled word, so read latency grows with the access width.

Top module: `abus_bridge`

## Requirements
- R1: The write kind comes from `cpu_addr`. If bit 8 is 1 the write is masked. Otherwise bits [7:6] give 01 = set, 10 = clear, and 00 or 11 = direct. The register index is `cpu_addr[5:0]`. `sl_op` carries 00 for direct, 01 for set, 10 for clear and 11 for masked.
- R2: A slave transaction lasts three cycles. `sl_req` is high in the first cycle only. `sl_we`, `sl_op`, `sl_addr`, `sl_nib` and `sl_wdata` hold steady through all three cycles. `sl_rdata` is sampled in the third cycle. The next `sl_req` comes no earlier than the cycle after that.
- R3: A direct, set or clear write with `cpu_size` 0, 1 or 2 issues 1, 2 or 4 transactions. Transaction k goes to register index+k (6-bit wrap) with `sl_nib`=0 and `sl_wdata` = `cpu_wdata[8k+7:8k]`. Size 3 behaves like size 2.
- R4: A masked write with size 0, 1 or 2 issues 1, 2 or 4 transactions. Transaction k goes to register index+k/2, with `sl_nib` = k mod 2, so the low nibble is written first. Its `sl_wdata` is {`cpu_wdata[16+4k+3:16+4k]` (mask), `cpu_wdata[4k+3:4k]` (value)}.
- R5: A read with size 0, 1 or 2 issues 2, 4 or 8 transactions with `sl_we`=0, using the same register and nibble order as R4. The nibble from transaction k lands in `cpu_rdata[4k+3:4k]`. All higher bits read as zero.
- R6: When the queue has room, a posted write raises `cpu_ready` in the cycle after it is accepted.
- R7: The write queue holds 4 entries. A write that arrives while the queue is full keeps `cpu_ready` low until an entry drains.
- R8: A non-posted write raises `cpu_ready` only after its own transactions and all earlier queued transactions have completed.
- R9: A read issues no transaction until every earlier write has completed. When nothing is pending, `cpu_ready` rises 3n+2 cycles after the accepting edge, where n is the number of read transactions.
- R10: `cpu_ready` is high for exactly one cycle per access. After reset, `cpu_ready` and `sl_req` are low and `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_posted | input | 1 | Write is posted |
| cpu_addr | input | 9 | Write kind and register index |
| cpu_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | Write data; for masked writes, mask in the upper half |
| cpu_ready | output | 1 | One-cycle completion |
| cpu_rdata | output | 32 | Assembled read data |
| sl_req | output | 1 | First cycle of a slave transaction |
| sl_we | output | 1 | Transaction is a write |
| sl_op | output | 2 | Write operation code |
| sl_addr | output | 6 | Slave register index |
| sl_nib | output | 1 | Nibble select |
| sl_wdata | output | 8 | Byte or {mask, value} |
| sl_rdata | input | 4 | Read nibble from the slave |

## Verification
The bench attacks four corner cases. The first is ordering: a read issued while posted writes are still queued. A design that let the read through early would return stale bytes and would see its nibble transactions interleaved with the writes. The second is nibble-split masked writes. If the nibble order were swapped, or the mask and value misrouted, the slave would take a wrong nibble, and the scoreboard catches that at the transaction level. The remaining cases are queue exhaustion, where a design that failed to stall would lose a write, and a non-posted write acknowledged before drain, which would show as pending expected transactions at the moment `cpu_ready` rises. Exact read latency and zero upper bits on narrow reads are also checked.

// File: rtl/abus_pkg.sv
package abus_pkg;
    localparam int CPU_AW = 9;
    localparam int REG_AW = 6;
    localparam int DW     = 32;

    typedef enum logic [1:0] {
        OP_DIRECT = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_MASK   = 2'd3
    } abus_op_e;

    typedef struct packed {
        logic              rd;
        abus_op_e          op;
        logic [REG_AW-1:0] reg_a;
        logic [1:0]        size;
        logic [DW-1:0]     data;
    } abus_job_t;

    // Size code 3 is folded onto the widest supported width.
    function automatic logic [1:0] eff_size(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

    // Reads move a nibble per transaction, writes a byte or a nibble pair.
    function automatic logic [3:0] txn_count(input logic rd, input logic [1:0] s);
        logic [1:0] e;
        e = eff_size(s);
        return rd ? (4'd2 << e) : (4'd1 << e);
    endfunction
endpackage

// File: rtl/abus_decode.sv
module abus_decode
    import abus_pkg::*;
#(
    parameter int TYPE_LSB = 6,
    parameter int MASK_BIT = 8
) (
    input  logic [CPU_AW-1:0] addr,
    output abus_op_e          op,
    output logic [REG_AW-1:0] reg_a
);
    always_comb begin
        reg_a = addr[REG_AW-1:0];
        if (addr[MASK_BIT]) begin
            op = OP_MASK;
        end else begin
            case (addr[TYPE_LSB +: 2])
                2'b01:   op = OP_SET;
                2'b10:   op = OP_CLEAR;
                default: op = OP_DIRECT;
            endcase
        end
    end
endmodule

// File: rtl/abus_wqueue.sv
module abus_wqueue
    import abus_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  abus_job_t din,
    input  logic      pop,
    output abus_job_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_st_t;

    q_st_t     s_d, s_q;
    abus_job_t slots [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = bump(s_q.wp);
        if (pop)  s_d.rp = bump(s_q.rp);
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) slots[s_q.wp] <= din;
    end

    assign head  = slots[s_q.rp];
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/abus_seq.sv
module abus_seq
    import abus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  abus_job_t         job,
    output logic              idle,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic              sl_req,
    output logic              sl_we,
    output logic [1:0]        sl_op,
    output logic [REG_AW-1:0] sl_addr,
    output logic              sl_nib,
    output logic [7:0]        sl_wdata,
    input  logic [3:0]        sl_rdata
);
    localparam logic [1:0] PH_ACK = 2'd2;

    typedef struct packed {
        logic              busy;
        logic [1:0]        ph;
        logic [2:0]        k;
        logic [3:0]        n;
        logic              rd;
        abus_op_e          op;
        logic [REG_AW-1:0] base;
        logic [DW-1:0]     data;
        logic [DW-1:0]     acc;
        logic              done;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    last;
    logic    nib_mode;

    assign last     = ({1'b0, s_q.k} == (s_q.n - 4'd1));
    assign nib_mode = s_q.rd || (s_q.op == OP_MASK);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.ph   = '0;
                s_d.k    = '0;
                s_d.n    = txn_count(job.rd, job.size);
                s_d.rd   = job.rd;
                s_d.op   = job.op;
                s_d.base = job.reg_a;
                s_d.data = job.data;
                s_d.acc  = '0;
            end
        end else if (s_q.ph == PH_ACK) begin
            if (s_q.rd) s_d.acc[{s_q.k, 2'b00} +: 4] = sl_rdata;
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.k  = s_q.k + 1'b1;
                s_d.ph = '0;
            end
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Slave-side fields derived from the transaction index.
    always_comb begin
        logic [2:0] bidx;
        int         kb;
        kb       = int'(s_q.k[1:0]);
        bidx     = nib_mode ? {1'b0, s_q.k[2:1]} : s_q.k;
        sl_addr  = s_q.base + REG_AW'(bidx);
        sl_nib   = nib_mode & s_q.k[0];
        if (s_q.op == OP_MASK)
            sl_wdata = {s_q.data[(DW/2) + 4*kb +: 4], s_q.data[4*kb +: 4]};
        else
            sl_wdata = s_q.data[8*kb +: 8];
    end

    assign sl_req = s_q.busy && (s_q.ph == '0);
    assign sl_we  = s_q.busy && !s_q.rd;
    assign sl_op  = s_q.op;
    assign idle   = !s_q.busy;
    assign done   = s_q.done;
    assign rdata  = s_q.acc;

    p_req_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sl_req |=> (!sl_req ##1 !sl_req));
    p_fields_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.ph != 2'd0) |-> ($stable(sl_addr) && $stable(sl_wdata)
                                          && $stable(sl_nib) && $stable(sl_we)));
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!idle));
endmodule

// File: rtl/abus_bridge.sv
module abus_bridge
    import abus_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_posted,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_ready,
    output logic [DW-1:0]     cpu_rdata,
    output logic              sl_req,
    output logic              sl_we,
    output logic [1:0]        sl_op,
    output logic [REG_AW-1:0] sl_addr,
    output logic              sl_nib,
    output logic [7:0]        sl_wdata,
    input  logic [3:0]        sl_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_NP_WAIT, S_RD_WAIT, S_RD_RUN, S_RESP
    } cpu_state_e;

    typedef struct packed {
        cpu_state_e    state;
        abus_job_t     rjob;
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t           s_d, s_q;
    abus_op_e          dec_op;
    logic [REG_AW-1:0] dec_reg;
    abus_job_t         wjob, q_head, eng_job;
    logic              push, pop, q_full, q_empty;
    logic              eng_start, eng_idle, eng_done;
    logic [DW-1:0]     eng_rdata;

    abus_decode u_decode (
        .addr  (cpu_addr),
        .op    (dec_op),
        .reg_a (dec_reg)
    );

    abus_wqueue #(.DEPTH(QDEPTH)) u_wqueue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wjob),
        .pop   (pop),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    abus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .job      (eng_job),
        .idle     (eng_idle),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .sl_req   (sl_req),
        .sl_we    (sl_we),
        .sl_op    (sl_op),
        .sl_addr  (sl_addr),
        .sl_nib   (sl_nib),
        .sl_wdata (sl_wdata),
        .sl_rdata (sl_rdata)
    );

    assign wjob = '{rd: 1'b0, op: dec_op, reg_a: dec_reg, size: cpu_size, data: cpu_wdata};

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        case (s_q.state)
            S_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (!q_full) begin
                            push      = 1'b1;
                            s_d.state = cpu_posted ? S_RESP : S_NP_WAIT;
                        end
                    end else begin
                        s_d.rjob  = '{rd: 1'b1, op: OP_DIRECT, reg_a: dec_reg,
                                      size: cpu_size, data: '0};
                        s_d.state = S_RD_WAIT;
                    end
                end
            end
            S_NP_WAIT: if (q_empty && eng_idle) s_d.state = S_RESP;
            S_RD_WAIT: if (q_empty && eng_idle) s_d.state = S_RD_RUN;
            S_RD_RUN: begin
                if (eng_done) begin
                    s_d.rdata = eng_rdata;
                    s_d.state = S_RESP;
                end
            end
            default:  s_d.state = S_IDLE;
        endcase
    end

    // Queued writes always go first; a read starts only on an empty queue.
    always_comb begin
        pop       = eng_idle && !q_empty;
        eng_start = pop || (s_q.state == S_RD_WAIT && q_empty && eng_idle);
        eng_job   = pop ? q_head : s_q.rjob;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_ready = (s_q.state == S_RESP);
    assign cpu_rdata = s_q.rdata;

    p_single_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    p_read_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_job.rd) |-> q_empty);
endmodule

// File: tb/abus_bridge_bench.sv
module abus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_posted = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        sl_req, sl_we, sl_nib;
    logic [1:0]  sl_op;
    logic [5:0]  sl_addr;
    logic [7:0]  sl_wdata;
    logic [3:0]  sl_rdata;

    always #2 clk = ~clk;

    abus_bridge u_abus_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_posted(cpu_posted), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .sl_req(sl_req), .sl_we(sl_we), .sl_op(sl_op), .sl_addr(sl_addr),
        .sl_nib(sl_nib), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata)
    );

    logic [7:0]  smem [64];
    logic [7:0]  rmem [64];
    logic [17:0] exp_q [$];
    int          checks = 0, fails = 0;
    bit          finished = 0;

    assign sl_rdata = sl_nib ? smem[sl_addr][7:4] : smem[sl_addr][3:0];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] apply(input logic [7:0] b, input logic [1:0] op,
                                         input logic nib, input logic [7:0] w);
        logic [3:0] m, v, old;
        case (op)
            2'd0: return w;
            2'd1: return b | w;
            2'd2: return b & ~w;
            default: begin
                m = w[7:4]; v = w[3:0];
                old = nib ? b[7:4] : b[3:0];
                old = (old & ~m) | (v & m);
                return nib ? {old, b[3:0]} : {b[7:4], old};
            end
        endcase
    endfunction

    // Scoreboard monitor: transaction order, content and R2 shape.
    int          ncyc = 0, last_req = -10, hold = 0;
    logic [17:0] held;
    always @(negedge clk) begin
        logic [17:0] a, e;
        ncyc++;
        if (rst_n) begin
            a = {sl_we, sl_op, sl_addr, sl_nib, sl_wdata};
            if (hold > 0) begin
                chk(a == held && !sl_req, "R2 fields held", {14'd0, a}, {14'd0, held});
                hold--;
            end
            if (sl_req) begin
                chk(ncyc - last_req >= 3, "R2 spacing", ncyc - last_req, 3);
                last_req = ncyc;
                held = a;
                hold = 2;
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected transaction", {14'd0, a}, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (!e[17])
                        chk(a[17] == 1'b0 && a[14:8] == e[14:8], "R5 read txn",
                            {14'd0, a}, {14'd0, e});
                    else
                        chk(a == e, "R1 R3 R4 write txn", {14'd0, a}, {14'd0, e});
                end
                if (sl_we) smem[sl_addr] = apply(smem[sl_addr], sl_op, sl_nib, sl_wdata);
            end
        end
    end

    task automatic drive(input bit we, input bit posted, input logic [8:0] addr,
                         input logic [1:0] sz, input logic [31:0] wd,
                         output int waits, output logic [31:0] rdv);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_posted = posted;
        cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
        waits = 0;
        do begin @(negedge clk); waits++; end while (!cpu_ready);
        rdv = cpu_rdata;
        @(negedge clk);
        chk(!cpu_ready, "R10 one-cycle ready", {31'd0, cpu_ready}, 0);
        cpu_req = 0;
    endtask

    task automatic do_write(input logic [8:0] addr, input logic [1:0] sz,
                            input logic [31:0] wd, input bit posted, output int waits);
        int n;
        logic [1:0]  op;
        logic [5:0]  b;
        logic        nib;
        logic [7:0]  w;
        logic [31:0] dummy;
        n = 1 << ((sz == 2'd3) ? 2 : int'(sz));
        if (addr[8])                  op = 2'd3;
        else if (addr[7:6] == 2'b01)  op = 2'd1;
        else if (addr[7:6] == 2'b10)  op = 2'd2;
        else                          op = 2'd0;
        for (int k = 0; k < n; k++) begin
            if (op == 2'd3) begin
                b = addr[5:0] + 6'(k / 2); nib = (k % 2) == 1;
                w = {wd[16 + 4*k +: 4], wd[4*k +: 4]};
            end else begin
                b = addr[5:0] + 6'(k); nib = 1'b0; w = wd[8*k +: 8];
            end
            exp_q.push_back({1'b1, op, b, nib, w});
            rmem[b] = apply(rmem[b], op, nib, w);
        end
        drive(1, posted, addr, sz, wd, waits, dummy);
        if (!posted) chk(exp_q.size() == 0, "R8 non-posted drained", exp_q.size(), 0);
    endtask

    task automatic do_read(input logic [8:0] addr, input logic [1:0] sz, input bit exact);
        int n, waits;
        logic [5:0]  b;
        logic        nib;
        logic [31:0] expv, v;
        n = 2 << ((sz == 2'd3) ? 2 : int'(sz));
        expv = '0;
        for (int k = 0; k < n; k++) begin
            b = addr[5:0] + 6'(k / 2); nib = (k % 2) == 1;
            exp_q.push_back({1'b0, 2'd0, b, nib, 8'd0});
            expv[4*k +: 4] = nib ? rmem[b][7:4] : rmem[b][3:0];
        end
        drive(0, 0, addr, sz, 32'd0, waits, v);
        chk(v == expv, "R5 read data", v, expv);
        chk(exp_q.size() == 0, "R9 read after writes", exp_q.size(), 0);
        if (exact) chk(waits == 3*n + 3, "R9 read latency", waits, 3*n + 3);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL timeout R10 actual=%0d expected=%0d", 60000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        int ws [7];
        for (int i = 0; i < 64; i++) begin smem[i] = 8'h00; rmem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(!cpu_ready, "R10 reset ready", {31'd0, cpu_ready}, 0);
        chk(!sl_req, "R10 reset sl_req", {31'd0, sl_req}, 0);
        chk(cpu_rdata == 0, "R10 reset rdata", cpu_rdata, 0);
        rst_n = 1;

        do_write(9'h004, 2'd2, 32'hA1B2C3D4, 1, w);
        chk(w == 1, "R6 posted ack", w, 1);
        do_read(9'h004, 2'd2, 0);
        do_read(9'h005, 2'd0, 1);

        do_write(9'h044, 2'd1, 32'h0000_0F0F, 1, w);
        do_write(9'h086, 2'd0, 32'h0000_0081, 1, w);
        do_write(9'h0D0, 2'd0, 32'h0000_005A, 0, w);
        do_read(9'h004, 2'd2, 1);
        do_read(9'h010, 2'd1, 1);

        do_write(9'h120, 2'd0, 32'h0006_000F, 1, w);
        do_write(9'h121, 2'd1, 32'h00F3_005C, 1, w);
        do_write(9'h122, 2'd2, 32'hFF0F_1234, 0, w);
        do_read(9'h020, 2'd2, 1);
        do_read(9'h020, 2'd1, 1);

        for (int i = 0; i < 7; i++)
            do_write(9'(9'h024 + 4*i), 2'd2, 32'h1000_0001 * (i + 3), 1, ws[i]);
        for (int i = 1; i < 4; i++) chk(ws[i] == 1, "R6 posted ack queued", ws[i], 1);
        chk(ws[6] > 1, "R7 full queue stall", ws[6], 2);
        do_read(9'h024, 2'd2, 0);
        do_read(9'h03C, 2'd2, 1);

        do_write(9'h000, 2'd3, 32'hDEADBEEF, 0, w);
        do_read(9'h000, 2'd3, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule